// File: doc/BRIEF.md
# Split Direct-Mapped Translation Cache

This block keeps recently used page translations close to the address path so that most accesses skip the page walk. It holds two independent direct-mapped arrays. One serves data accesses and the other serves instruction fetches, and the code bit of each request chooses between them. A lookup presents a linear address together with its write, user and code attributes, plus the current write-protect setting. One clock later the block returns a hit flag and the translated physical address.

A hit is reported only when three things hold. The slot must be valid and its tag must match. The stored rights must allow the request. A write must also find the entry already marked dirty, because a write to a clean page has to go back through the walker so the walker can set the dirty bit in memory. The page walker fills entries through an update port. Three maintenance inputs remove entries: a full flush, a flush that spares global pages, and a single-page invalidate. All of them take effect in one cycle.

Top module: `tlb_split_dm`

## Requirements
- R1: After reset every slot of both arrays is invalid. `rsp_hit` and `rsp_paddr` read 0 during reset and after it.
- R2: The result of a lookup appears on the clock edge after it is presented. On a hit, `rsp_paddr` is the stored frame (bits 31:12) joined with the request's address bits 11:0. On a miss, or when no lookup is presented, `rsp_hit` is 0 and `rsp_paddr` is 0.
- R3: An update with `upd_code`=0 fills the data array and one with `upd_code`=1 fills the code array. A lookup searches only the array chosen by its `lk_code` bit.
- R4: Linear address bits 17:12 select the slot and bits 31:18 form the tag. A lookup whose tag differs from the stored one misses. An update replaces whatever the slot held.
- R5: Rights check. A supervisor read always passes. A supervisor write passes when the entry is writable or `wp_en` is 0. A user access needs the entry's user flag, and a user write also needs its writable flag. A lookup that fails the check misses.
- R6: A write lookup that hits an entry whose dirty flag is clear reports a miss.
- R7: `flush_all` invalidates every entry of both arrays, including global ones.
- R8: `flush_local` invalidates only entries whose global flag is clear. The update's `upd_pte` bit 8 is the global flag, honoured only when `GLOBAL_EN`=1. Bit 6 of `upd_pte` is the dirty flag.
- R9: `inval_valid` examines the slot selected by `inval_laddr` in both arrays. It clears each one whose tag matches and leaves a slot with a different tag valid.
- R10: An update presented in the same cycle as `flush_all`, `flush_local` or `inval_valid` is discarded.
- R11: An update takes every flag from the new request. A previously dirty entry rewritten with a clean table entry misses the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_laddr | input | 32 | Lookup linear address |
| lk_code | input | 1 | Lookup is an instruction fetch (selects the code array) |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup is from user privilege |
| wp_en | input | 1 | Supervisor write protection enabled |
| upd_valid | input | 1 | Walker fill request |
| upd_laddr | input | 32 | Linear address being filled |
| upd_code | input | 1 | Fill targets the code array |
| upd_pte | input | 32 | Final table entry: frame 31:12, global bit 8, dirty bit 6 |
| upd_wr | input | 1 | Effective writable right from the walk |
| upd_usr | input | 1 | Effective user right from the walk |
| flush_all | input | 1 | Invalidate all entries |
| flush_local | input | 1 | Invalidate all non-global entries |
| inval_valid | input | 1 | Invalidate one page |
| inval_laddr | input | 32 | Linear address of the page to invalidate |
| rsp_hit | output | 1 | Registered lookup hit |
| rsp_paddr | output | 32 | Registered physical address, 0 on miss |

## Verification
Lookups are issued against a mix of entries: data and code entries sharing one slot index, entries with and without the dirty, writable, user and global flags, and aliases that differ only in the tag bits. Each combination of write, user and write-protect is tried on these entries, which separates the rights check from the dirty rule and from tag matching. Flushes and single-page invalidates are applied both alone and in the same cycle as a fill. This shows whether global pages survive, whether the other array and other tags are left alone, and whether the fill is dropped. A behavioural model in the bench predicts every registered response, and the DUT is compared against it on every clock.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int unsigned LA_W        = 32;
  localparam int unsigned PG_OFF_W    = 12;
  localparam int unsigned SLOT_W      = 6;
  localparam int unsigned TAG_W       = LA_W - PG_OFF_W - SLOT_W;
  localparam int unsigned FRM_W       = LA_W - PG_OFF_W;
  localparam int unsigned PTE_DIRTY_B = 6;
  localparam int unsigned PTE_GLOB_B  = 8;
  localparam int unsigned N_ARRAYS    = 2;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [FRM_W-1:0] frame;
    logic             wr;
    logic             usr;
    logic             dirty;
    logic             glob;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlbx_pkg::*;
(
  input  logic rq_wr,
  input  logic rq_usr,
  input  logic wp,
  input  logic e_wr,
  input  logic e_usr,
  input  logic e_dirty,
  output logic ok
);
  logic rights_ok;

  always_comb begin
    if (rq_usr) begin
      rights_ok = e_usr && (!rq_wr || e_wr);
    end else begin
      rights_ok = !rq_wr || e_wr || !wp;
    end
    // a write to a clean page must go back to the walker
    ok = rights_ok && (!rq_wr || e_dirty);
  end
endmodule

// File: rtl/tlb_way.sv
module tlb_way
  import tlbx_pkg::*;
#(
  parameter int unsigned IDX_W     = SLOT_W,
  parameter bit          GLOBAL_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output tlb_ent_t         rd_ent,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic             flush_all,
  input  logic             flush_ng,
  input  logic             inval_en,
  input  logic [IDX_W-1:0] inval_idx,
  input  logic [TAG_W-1:0] inval_tag
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] glob_q;
  tlb_ent_t         ent_q [DEPTH];
  logic             maint;
  logic             wr_take;
  logic             inval_hit;

  assign maint     = flush_all || flush_ng || inval_en;
  assign wr_take   = wr_en && !maint;
  assign inval_hit = inval_en && vld_q[inval_idx] && (ent_q[inval_idx].tag == inval_tag);

  // next-state of the valid vector
  always_comb begin
    vld_d = vld_q;
    if (flush_all) begin
      vld_d = '0;
    end else if (flush_ng) begin
      vld_d = vld_q & glob_q;
    end
    if (inval_hit) begin
      vld_d[inval_idx] = 1'b0;
    end
    if (wr_take) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // payload storage, no reset, written under clock enable
  always_ff @(posedge clk) begin
    if (wr_take) begin
      ent_q[wr_idx]  <= wr_ent;
      glob_q[wr_idx] <= wr_ent.glob & GLOBAL_EN;
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/tlb_split_dm.sv
module tlb_split_dm
  import tlbx_pkg::*;
#(
  parameter bit GLOBAL_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [LA_W-1:0] lk_laddr,
  input  logic            lk_code,
  input  logic            lk_write,
  input  logic            lk_user,
  input  logic            wp_en,
  input  logic            upd_valid,
  input  logic [LA_W-1:0] upd_laddr,
  input  logic            upd_code,
  input  logic [LA_W-1:0] upd_pte,
  input  logic            upd_wr,
  input  logic            upd_usr,
  input  logic            flush_all,
  input  logic            flush_local,
  input  logic            inval_valid,
  input  logic [LA_W-1:0] inval_laddr,
  output logic            rsp_hit,
  output logic [LA_W-1:0] rsp_paddr
);
  localparam int unsigned IDX_LO = PG_OFF_W;
  localparam int unsigned TAG_LO = PG_OFF_W + SLOT_W;

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [N_ARRAYS-1:0] way_vld;
  tlb_ent_t        way_ent [N_ARRAYS];
  tlb_ent_t        new_ent;
  tlb_ent_t        sel_ent;
  logic            sel_vld;
  logic            sel_dirty;
  logic            tag_eq;
  logic            perm_ok;
  logic            hit_d;
  logic [LA_W-1:0] paddr_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    new_ent.tag   = upd_laddr[LA_W-1:TAG_LO];
    new_ent.frame = upd_pte[LA_W-1:PG_OFF_W];
    new_ent.wr    = upd_wr;
    new_ent.usr   = upd_usr;
    new_ent.dirty = upd_pte[PTE_DIRTY_B];
    new_ent.glob  = upd_pte[PTE_GLOB_B] & GLOBAL_EN;
  end

  for (genvar g = 0; g < N_ARRAYS; g++) begin : g_arr
    tlb_way #(
      .IDX_W    (SLOT_W),
      .GLOBAL_EN(GLOBAL_EN)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .rd_idx   (lk_laddr[TAG_LO-1:IDX_LO]),
      .rd_vld   (way_vld[g]),
      .rd_ent   (way_ent[g]),
      .wr_en    (upd_valid && (upd_code == g[0])),
      .wr_idx   (upd_laddr[TAG_LO-1:IDX_LO]),
      .wr_ent   (new_ent),
      .flush_all(flush_all),
      .flush_ng (flush_local),
      .inval_en (inval_valid),
      .inval_idx(inval_laddr[TAG_LO-1:IDX_LO]),
      .inval_tag(inval_laddr[LA_W-1:TAG_LO])
    );
  end

  assign sel_vld   = way_vld[lk_code];
  assign sel_ent   = way_ent[lk_code];
  assign sel_dirty = sel_ent.dirty;
  assign tag_eq    = (sel_ent.tag == lk_laddr[LA_W-1:TAG_LO]);

  tlb_perm u_perm (
    .rq_wr  (lk_write),
    .rq_usr (lk_user),
    .wp     (wp_en),
    .e_wr   (sel_ent.wr),
    .e_usr  (sel_ent.usr),
    .e_dirty(sel_ent.dirty),
    .ok     (perm_ok)
  );

  always_comb begin
    hit_d   = lk_valid && sel_vld && tag_eq && perm_ok;
    paddr_d = hit_d ? {sel_ent.frame, lk_laddr[PG_OFF_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= hit_d;
      rsp_paddr <= paddr_d;
    end
  end
endmodule

// File: rtl/tlb_split_dm_chk.sv
module tlb_split_dm_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        lk_valid,
  input logic        lk_write,
  input logic [31:0] lk_laddr,
  input logic        flush_all,
  input logic        sel_dirty,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr
);
  assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !rsp_hit);

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_hit |-> (rsp_paddr == 32'h0));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_hit |-> (rsp_paddr[11:0] == $past(lk_laddr[11:0])));

  assert_write_dirty_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_hit && $past(lk_write)) |-> $past(sel_dirty));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && $past(flush_all)) |=> !rsp_hit);
endmodule

bind tlb_split_dm tlb_split_dm_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .lk_valid  (lk_valid),
  .lk_write  (lk_write),
  .lk_laddr  (lk_laddr),
  .flush_all (flush_all),
  .sel_dirty (sel_dirty),
  .rsp_hit   (rsp_hit),
  .rsp_paddr (rsp_paddr)
);

// File: tb/tb_tlb_split_dm.sv
module tb_tlb_split_dm;
  logic        clk;
  logic        rst_n;
  logic        lk_valid, lk_code, lk_write, lk_user, wp_en;
  logic [31:0] lk_laddr;
  logic        upd_valid, upd_code, upd_wr, upd_usr;
  logic [31:0] upd_laddr, upd_pte;
  logic        flush_all, flush_local, inval_valid;
  logic [31:0] inval_laddr;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  bit          m_v  [2][64];
  int unsigned m_tag[2][64];
  int unsigned m_frm[2][64];
  bit          m_w  [2][64];
  bit          m_u  [2][64];
  bit          m_d  [2][64];
  bit          m_g  [2][64];
  bit          exp_hit;
  logic [31:0] exp_pa;

  tlb_split_dm dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_laddr(lk_laddr), .lk_code(lk_code),
    .lk_write(lk_write), .lk_user(lk_user), .wp_en(wp_en),
    .upd_valid(upd_valid), .upd_laddr(upd_laddr), .upd_code(upd_code),
    .upd_pte(upd_pte), .upd_wr(upd_wr), .upd_usr(upd_usr),
    .flush_all(flush_all), .flush_local(flush_local),
    .inval_valid(inval_valid), .inval_laddr(inval_laddr),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic idle_inputs();
    lk_valid = 0; lk_laddr = 0; lk_code = 0; lk_write = 0; lk_user = 0; wp_en = 0;
    upd_valid = 0; upd_laddr = 0; upd_code = 0; upd_pte = 0; upd_wr = 0; upd_usr = 0;
    flush_all = 0; flush_local = 0; inval_valid = 0; inval_laddr = 0;
  endtask

  function automatic bit model_allow(bit w, bit u, bit ew, bit eu, bit ed, bit wp);
    bit r;
    if (u) r = eu && (!w || ew);
    else   r = !w || ew || !wp;
    if (w && !ed) r = 0;
    return r;
  endfunction

  task automatic model_edge();
    int a  = lk_code;
    int ix = (lk_laddr >> 12) & 63;
    int iv = (inval_laddr >> 12) & 63;
    bit blk;
    exp_hit = lk_valid && m_v[a][ix] && (m_tag[a][ix] == (lk_laddr >> 18)) &&
              model_allow(lk_write, lk_user, m_w[a][ix], m_u[a][ix], m_d[a][ix], wp_en);
    exp_pa  = exp_hit ? ((m_frm[a][ix] << 12) | (lk_laddr & 32'hFFF)) : 32'h0;
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 64; s++) begin
        if (flush_all) m_v[k][s] = 0;
        else if (flush_local && !m_g[k][s]) m_v[k][s] = 0;
      end
      if (inval_valid && m_v[k][iv] && m_tag[k][iv] == (inval_laddr >> 18)) m_v[k][iv] = 0;
    end
    blk = flush_all || flush_local || inval_valid;
    if (upd_valid && !blk) begin
      int b = upd_code;
      int j = (upd_laddr >> 12) & 63;
      m_v[b][j]   = 1;
      m_tag[b][j] = upd_laddr >> 18;
      m_frm[b][j] = upd_pte >> 12;
      m_w[b][j]   = upd_wr;
      m_u[b][j]   = upd_usr;
      m_d[b][j]   = upd_pte[6];
      m_g[b][j]   = upd_pte[8];
    end
  endtask

  // one clock: model at the edge, compare at the following falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (rsp_hit !== exp_hit || rsp_paddr !== exp_pa) begin
      errors++;
      $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
               tag, rsp_hit, rsp_paddr, exp_hit, exp_pa);
    end
    idle_inputs();
  endtask

  task automatic look(logic [31:0] la, bit code, bit wr, bit usr, bit wp, string tag);
    lk_valid = 1; lk_laddr = la; lk_code = code; lk_write = wr; lk_user = usr; wp_en = wp;
    cyc(tag);
  endtask

  task automatic fill(logic [31:0] la, bit code, logic [31:0] pte, bit w, bit u, string tag);
    upd_valid = 1; upd_laddr = la; upd_code = code; upd_pte = pte; upd_wr = w; upd_usr = u;
    cyc(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 64; s++) begin
        m_v[k][s] = 0; m_tag[k][s] = 0; m_frm[k][s] = 0;
        m_w[k][s] = 0; m_u[k][s] = 0; m_d[k][s] = 0; m_g[k][s] = 0;
      end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_hit !== 1'b0 || rsp_paddr !== 32'h0) begin
      errors++;
      $display("FAIL R1: in reset hit=%0b paddr=%h expected 0/0", rsp_hit, rsp_paddr);
    end
    rst_n = 1;
    repeat (3) cyc("R1");
    look(32'h0000_1234, 0, 0, 0, 0, "R1");

    // data entry: writable, user, dirty; slot 3
    fill(32'h0040_3000, 0, 32'hABCD_E040, 1, 1, "R3");
    look(32'h0040_3123, 0, 0, 1, 0, "R2");
    look(32'h0040_3123, 1, 0, 1, 0, "R3");
    look(32'h0080_3123, 0, 0, 0, 0, "R4");
    look(32'h0040_3FFC, 0, 1, 1, 1, "R5");
    cyc("R2");

    // code entry in slot 3: global, clean, read-only, supervisor
    fill(32'h0080_3000, 1, 32'h1111_1100, 0, 0, "R8");
    look(32'h0080_3ABC, 1, 0, 0, 0, "R3");
    look(32'h0080_3ABC, 1, 0, 1, 0, "R5");
    look(32'h0080_3ABC, 1, 1, 0, 1, "R5");
    look(32'h0080_3ABC, 1, 1, 0, 0, "R6");
    look(32'h0040_3ABC, 0, 0, 0, 0, "R3");

    // data entry read-only dirty supervisor, slot 5
    fill(32'h1230_5000, 0, 32'h2222_2040, 0, 0, "R5");
    look(32'h1230_5010, 0, 1, 0, 0, "R5");
    look(32'h1230_5010, 0, 1, 0, 1, "R5");
    look(32'h1230_5010, 0, 0, 1, 0, "R5");

    // writable but clean data entry, slot 7
    fill(32'h0000_7000, 0, 32'h3333_3000, 1, 1, "R6");
    look(32'h0000_7008, 0, 0, 1, 0, "R6");
    look(32'h0000_7008, 0, 1, 1, 0, "R6");

    // non-global flush keeps the global code page
    flush_local = 1; cyc("R8");
    look(32'h0080_3ABC, 1, 0, 0, 0, "R8");
    look(32'h0040_3123, 0, 0, 1, 0, "R8");
    look(32'h1230_5010, 0, 0, 0, 0, "R8");

    // single page invalidate: same slot, different tag in data array survives
    fill(32'h0040_3000, 0, 32'hABCD_E040, 1, 1, "R9");
    inval_valid = 1; inval_laddr = 32'h0080_3555; cyc("R9");
    look(32'h0080_3ABC, 1, 0, 0, 0, "R9");
    look(32'h0040_3123, 0, 0, 1, 0, "R9");
    inval_valid = 1; inval_laddr = 32'h0040_3000; cyc("R9");
    look(32'h0040_3123, 0, 0, 1, 0, "R9");

    // overwrite clears old dirty flag
    fill(32'h0000_9000, 0, 32'h4444_4040, 1, 0, "R11");
    look(32'h0000_9004, 0, 1, 0, 0, "R11");
    fill(32'h0000_9000, 0, 32'h5555_5000, 1, 0, "R11");
    look(32'h0000_9004, 0, 1, 0, 0, "R11");
    look(32'h0000_9004, 0, 0, 0, 0, "R11");

    // fill racing maintenance is dropped
    fill(32'h0080_3000, 1, 32'h1111_1140, 1, 1, "R10");
    upd_valid = 1; upd_laddr = 32'h0000_A000; upd_code = 0; upd_pte = 32'h6666_6040;
    upd_wr = 1; upd_usr = 1; flush_local = 1; cyc("R10");
    look(32'h0000_A000, 0, 0, 0, 0, "R10");
    upd_valid = 1; upd_laddr = 32'h0000_B000; upd_code = 1; upd_pte = 32'h7777_7040;
    inval_valid = 1; inval_laddr = 32'hFFFF_F000; cyc("R10");
    look(32'h0000_B000, 1, 0, 0, 0, "R10");
    look(32'h0080_3ABC, 1, 0, 0, 0, "R7");

    // full flush removes global pages too, and beats a same-cycle fill
    upd_valid = 1; upd_laddr = 32'h0000_C000; upd_code = 0; upd_pte = 32'h8888_8040;
    flush_all = 1; cyc("R7");
    look(32'h0080_3ABC, 1, 0, 0, 0, "R7");
    look(32'h0000_C000, 0, 0, 0, 0, "R10");
    look(32'h0000_9004, 0, 0, 0, 0, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule